// File: doc/BRIEF.md
# Timer Input Capture Unit

This block pairs a free-running up-counter with a capture register. An external pin is brought into the clock domain through a short synchronizer. When the selected pin event occurs, the current counter value is copied into the capture register. The selectable events are a falling transition, a rising transition, every fourth rising transition and every sixteenth rising transition. Each capture raises a sticky flag. The flag is visible to software together with the captured value. It can drive an interrupt line through an enable input.

Software selects the event with a 4-bit mode input. It reads the captured value and flag directly from the output ports, and clears the flag with a one-cycle strobe. The block has no overrun protection: a capture taken before software has read the previous one replaces it. The event prescaler is only reset by leaving the capture modes, so switching straight between the two divided modes keeps the partial count.

Top module: `tmr_capture_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `tmr_val`, `cap_val`, `cap_flag` and `irq` become zero. The event prescaler and the pin synchronizer also clear.
- R2: `tmr_val` rises by exactly one on every clock edge where `tmr_en` is high. It keeps its value on edges where `tmr_en` is low.
- R3: With `cap_mode` = 4'b0101, each 0-to-1 change of `cap_pin` causes exactly one capture. If the pin changes between clock edges, the capture lands on the third following rising clock edge and stores the `tmr_val` present just after the second of those edges.
- R4: With `cap_mode` = 4'b0100, each 1-to-0 change of `cap_pin` captures with the same latency as R3. In that mode a 0-to-1 change captures nothing, and in mode 4'b0101 a 1-to-0 change captures nothing: `cap_flag` stays clear and `cap_val` keeps its value.
- R5: With `cap_mode` = 4'b0110, counting from a cleared prescaler, the 4th, 8th, 12th and later multiples-of-4 rising pin changes capture, and the others do not.
- R6: With `cap_mode` = 4'b0111, counting from a cleared prescaler, only every 16th rising pin change captures.
- R7: Mode 4'b0000 (off) and every code outside 4'b0100 to 4'b0111 capture nothing and hold the prescaler at zero. The prescaler counts rising pin changes only in modes 4'b0110 and 4'b0111. It keeps its count in modes 4'b0100 and 4'b0101.
- R8: Switching directly from 4'b0110 to 4'b0111 keeps the prescaler count. After two rising changes in 4'b0110, the 14th rising change after the switch captures.
- R9: Every capture sets `cap_flag`. The flag stays set until a cycle with `flag_clr` high and no capture clears it. If a capture and `flag_clr` fall in the same cycle, the flag ends up set.
- R10: A capture taken while `cap_flag` is still set replaces `cap_val` with the new timer value, and `cap_flag` stays set.
- R11: `irq` is a register that loads the next flag value ANDed with `irq_en` on each clock edge. `irq` therefore follows a change of `irq_en` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | Counter increment enable |
| cap_pin | input | 1 | Asynchronous external event pin |
| cap_mode | input | 4 | Event selection code |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Software strobe that clears the capture flag |
| tmr_val | output | TMR_W | Free-running counter value |
| cap_val | output | TMR_W | Last captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| irq | output | 1 | Interrupt request, flag gated by enable |

## Verification
A prescaler that holds a wrong count shows up as a capture on the wrong rising pin change. The error appears within at most sixteen pin changes, and the bench counts edges to name the one that must capture. A synchronizer with the wrong depth, or an edge detector that pulses twice, gives a captured value off by one or more timer ticks. It can also give a second, unexpected flag rise, and both are visible three clock edges after the pin moves. A wrong priority between flag clear and capture, or wrong flag gating, shows on `cap_flag` or `irq` at the very next edge.

// File: rtl/cap_pkg.sv
package cap_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    CM_OFF   = 4'h0,
    CM_FALL  = 4'h4,
    CM_RISE  = 4'h5,
    CM_DIV4  = 4'h6,
    CM_DIV16 = 4'h7
  } cap_mode_e;

  // True for the four codes that take captures
  function automatic logic mode_active(input logic [MODE_W-1:0] m);
    return (m == CM_FALL) || (m == CM_RISE) || (m == CM_DIV4) || (m == CM_DIV16);
  endfunction

endpackage

// File: rtl/cap_pin_sync.sv
module cap_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;
  logic              synced;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign synced = chain_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= synced;
  end

  // One pulse per settled transition
  assign rise_o = synced & ~last_q;
  assign fall_o = ~synced & last_q;

endmodule

// File: rtl/cap_event_qual.sv
module cap_event_qual
  import cap_pkg::*;
#(
  parameter int PSC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              evt_o,
  output logic [PSC_W-1:0]  psc_o
);

  // Short ratio uses the low half of the counter, long ratio all of it
  localparam int SHORT_W = PSC_W / 2;

  logic [PSC_W-1:0] cnt_q;
  logic             counting;

  assign counting = (mode_i == CM_DIV4) || (mode_i == CM_DIV16);

  always_ff @(posedge clk) begin
    if (rst || !mode_active(mode_i)) cnt_q <= '0;
    else if (counting && rise_i)     cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    case (mode_i)
      CM_FALL:  evt_o = fall_i;
      CM_RISE:  evt_o = rise_i;
      CM_DIV4:  evt_o = rise_i && (&cnt_q[SHORT_W-1:0]);
      CM_DIV16: evt_o = rise_i && (&cnt_q);
      default:  evt_o = 1'b0;
    endcase
  end

  assign psc_o = cnt_q;

endmodule

// File: rtl/cap_free_timer.sv
module cap_free_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  output logic [W-1:0] val_o
);

  always_ff @(posedge clk) begin
    if (rst)       val_o <= '0;
    else if (en_i) val_o <= val_o + 1'b1;
  end

endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import cap_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PSC_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tmr_en,
  input  logic              cap_pin,
  input  logic [MODE_W-1:0] cap_mode,
  input  logic              irq_en,
  input  logic              flag_clr,
  output logic [TMR_W-1:0]  tmr_val,
  output logic [TMR_W-1:0]  cap_val,
  output logic              cap_flag,
  output logic              irq
);

  logic             pin_rise;
  logic             pin_fall;
  logic             cap_evt;
  logic [PSC_W-1:0] psc_cnt;
  logic             flag_nxt;

  cap_free_timer #(.W(TMR_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .en_i  (tmr_en),
    .val_o (tmr_val)
  );

  cap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (cap_pin),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  cap_event_qual #(.PSC_W(PSC_W)) u_qual (
    .clk    (clk),
    .rst    (rst),
    .mode_i (cap_mode),
    .rise_i (pin_rise),
    .fall_i (pin_fall),
    .evt_o  (cap_evt),
    .psc_o  (psc_cnt)
  );

  // Capture beats a same-cycle clear
  always_comb begin
    if (cap_evt)       flag_nxt = 1'b1;
    else if (flag_clr) flag_nxt = 1'b0;
    else               flag_nxt = cap_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_val  <= '0;
      cap_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (cap_evt) cap_val <= tmr_val;
      cap_flag <= flag_nxt;
      irq      <= flag_nxt & irq_en;
    end
  end

endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
  parameter int TMR_W = 16,
  parameter int PSC_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tmr_en,
  input logic             flag_clr,
  input logic             cap_evt,
  input logic             pin_rise,
  input logic             cap_flag,
  input logic             irq,
  input logic [3:0]       cap_mode,
  input logic [PSC_W-1:0] psc_cnt,
  input logic [TMR_W-1:0] tmr_val,
  input logic [TMR_W-1:0] cap_val
);

  // R2
  tmr_step_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_en |=> tmr_val == TMR_W'($past(tmr_val) + 1'b1));

  // R2
  tmr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tmr_en |=> $stable(tmr_val));

  // R3
  edge_once_chk: assert property (@(posedge clk) disable iff (rst)
    pin_rise |=> !pin_rise);

  // R7
  psc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_mode < 4'h4 || cap_mode > 4'h7) |=> psc_cnt == '0);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> cap_flag);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_flag && !flag_clr) |=> cap_flag);

  // R10
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_evt |=> $stable(cap_val));

  // R11
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> cap_flag);

endmodule

bind tmr_capture_unit cap_unit_chk #(.TMR_W(TMR_W), .PSC_W(PSC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tmr_en   (tmr_en),
  .flag_clr (flag_clr),
  .cap_evt  (cap_evt),
  .pin_rise (pin_rise),
  .cap_flag (cap_flag),
  .irq      (irq),
  .cap_mode (cap_mode),
  .psc_cnt  (psc_cnt),
  .tmr_val  (tmr_val),
  .cap_val  (cap_val)
);

// File: tb/sim_tmr_capture_unit.sv
module sim_tmr_capture_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tmr_en = 1'b0;
  logic        cap_pin = 1'b0;
  logic [3:0]  cap_mode = 4'h0;
  logic        irq_en = 1'b0;
  logic        flag_clr = 1'b0;
  logic [15:0] tmr_val;
  logic [15:0] cap_val;
  logic        cap_flag;
  logic        irq;

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [15:0] exp_tmr;
  logic [15:0] exp_q[$];
  logic        flag_prev = 1'b0;
  string       cur_req = "R3";
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_capture_unit u0 (
    .clk(clk), .rst(rst), .tmr_en(tmr_en), .cap_pin(cap_pin),
    .cap_mode(cap_mode), .irq_en(irq_en), .flag_clr(flag_clr),
    .tmr_val(tmr_val), .cap_val(cap_val), .cap_flag(cap_flag), .irq(irq)
  );

  // Reference counter model
  always @(posedge clk) begin
    if (rst)         exp_tmr <= 16'd0;
    else if (tmr_en) exp_tmr <= exp_tmr + 16'd1;
  end

  // Monitor: every new flag rise must match the next queued capture
  always @(negedge clk) begin
    if (!rst && cap_flag && !flag_prev) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL %s unexpected capture act=%h exp=none", cur_req, cap_val);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if (cap_val !== e) begin
          n_fail++;
          $display("FAIL %s capture value act=%h exp=%h", cur_req, cap_val, e);
        end
      end
    end
    flag_prev <= cap_flag;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
  endtask

  // Drive pin; optionally queue the timer value the capture must hold
  task automatic set_pin(input logic v, input bit push);
    cap_pin = v;
    if (push) exp_q.push_back(exp_tmr + 16'd2);
    tick(4);
  endtask

  task automatic rise_pulse(input bit push);
    clr_flag();
    set_pin(1'b1, push);
    set_pin(1'b0, 1'b0);
  endtask

  task automatic fall_pulse(input bit push);
    clr_flag();
    set_pin(1'b1, 1'b0);
    set_pin(1'b0, push);
  endtask

  task automatic set_mode(input logic [3:0] m);
    cap_mode = m;
    tick(1);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_up();
  end

  initial begin
    logic [15:0] v;
    tick(4);
    rst = 1'b0;
    tick(3);
    // R1 reset state, R2 hold while disabled
    chk(cap_val == 16'd0, "R1 cap_val", 32'(cap_val), 0);
    chk(cap_flag == 1'b0, "R1 cap_flag", 32'(cap_flag), 0);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    chk(tmr_val == 16'd0, "R2 hold", 32'(tmr_val), 0);

    // R2 counting
    tmr_en = 1'b1;
    tick(7);
    chk(tmr_val == 16'd7 && tmr_val == exp_tmr, "R2 count", 32'(tmr_val), 7);

    // R3 rising captures, R4 falling ignored in rising mode
    cur_req = "R3";
    set_mode(4'h5);
    rise_pulse(1'b1);
    rise_pulse(1'b1);
    clr_flag();
    set_pin(1'b1, 1'b1);
    clr_flag();
    v = cap_val;
    set_pin(1'b0, 1'b0);
    chk(cap_flag == 1'b0, "R4 fall ignored flag", 32'(cap_flag), 0);
    chk(cap_val == v, "R4 fall ignored val", 32'(cap_val), 32'(v));

    // R4 falling mode
    cur_req = "R4";
    set_mode(4'h4);
    fall_pulse(1'b1);
    fall_pulse(1'b1);

    // R10 overwrite while flag set
    cur_req = "R10";
    set_mode(4'h5);
    clr_flag();
    set_pin(1'b1, 1'b1);
    set_pin(1'b0, 1'b0);
    v = exp_tmr + 16'd2;
    set_pin(1'b1, 1'b0);
    chk(cap_val == v, "R10 overwrite val", 32'(cap_val), 32'(v));
    chk(cap_flag == 1'b1, "R10 flag stays", 32'(cap_flag), 1);
    set_pin(1'b0, 1'b0);

    // R9 sticky flag and R11 gating
    tick(10);
    chk(cap_flag == 1'b1, "R9 sticky", 32'(cap_flag), 1);
    chk(irq == 1'b0, "R11 masked", 32'(irq), 0);
    irq_en = 1'b1;
    tick(1);
    chk(irq == 1'b1, "R11 enabled", 32'(irq), 1);
    clr_flag();
    chk(cap_flag == 1'b0, "R9 clear", 32'(cap_flag), 0);
    chk(irq == 1'b0, "R11 follows clear", 32'(irq), 0);
    irq_en = 1'b0;

    // R9 capture wins over same-cycle clear
    cur_req = "R9";
    cap_pin = 1'b1;
    exp_q.push_back(exp_tmr + 16'd2);
    tick(2);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    chk(cap_flag == 1'b1, "R9 capture beats clear", 32'(cap_flag), 1);
    tick(2);
    set_pin(1'b0, 1'b0);

    // R5 divide by 4
    cur_req = "R5";
    set_mode(4'h0);
    set_mode(4'h6);
    for (int k = 1; k <= 8; k++) rise_pulse(k % 4 == 0);

    // R6 divide by 16
    cur_req = "R6";
    set_mode(4'h0);
    set_mode(4'h7);
    for (int k = 1; k <= 16; k++) rise_pulse(k == 16);

    // R8 direct ratio change keeps count
    cur_req = "R8";
    set_mode(4'h0);
    set_mode(4'h6);
    rise_pulse(1'b0);
    rise_pulse(1'b0);
    set_mode(4'h7);
    for (int k = 1; k <= 14; k++) rise_pulse(k == 14);

    // R7 off and non-capture codes clear prescaler and capture nothing
    cur_req = "R7";
    set_mode(4'h6);
    rise_pulse(1'b0);
    rise_pulse(1'b0);
    set_mode(4'h8);
    rise_pulse(1'b0);
    set_mode(4'h6);
    for (int k = 1; k <= 4; k++) rise_pulse(k == 4);
    set_mode(4'h0);
    rise_pulse(1'b0);
    fall_pulse(1'b0);
    chk(cap_flag == 1'b0, "R7 off no capture", 32'(cap_flag), 0);

    tick(2);
    chk(exp_q.size() == 0, "R3 missing captures", 32'(exp_q.size()), 0);
    finish_up();
  end

endmodule